// File: doc/BRIEF.md
# Serial Port Interrupt Status Hub

This block sits beside the FIFOs and shifters of a serial port and turns their state into interrupt information. From the receive and transmit FIFO occupancy counts and two programmable trigger levels it forms a live status word. Every cycle, the level flags of that word are folded into a sticky interrupt register. Single-cycle event pulses for receive overrun, framing error, parity error, receive timeout, modem status change and transmit overflow are folded in as well.

Software clears the sticky register by writing ones. It shapes the interrupt mask through one port that can only set bits and another that can only clear them. A write to the mask itself has no effect. A single registered interrupt line is high whenever a masked-in sticky bit is set. The trigger thresholds are written over their own write strobes.

All pins are plain control and status signals. Each write strobe takes effect on the clock edge where it is sampled high. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `serial_irq_hub`

## Requirements
- R1: Status bit 0 is 1 while the RX count is greater than or equal to the RX trigger level. Bit 1 is 1 when the RX count is zero. Bit 2 is 1 when the RX count equals RX_DEPTH. The status word is combinational from the counts and the stored trigger levels.
- R2: Status bit 3 is 1 when the TX count is zero. Bit 4 is 1 when the TX count equals TX_DEPTH. Bit 13 is 1 while the TX count is greater than or equal to the TX trigger level. All other status bits are 0.
- R3: At each clock edge out of reset, the sticky bits 4..0 that match high status bits 4..0 are set, and sticky bit 10 is set if status bit 13 is high. Sticky bit 11 is always 0.
- R4: An event pulse sampled at an edge sets its sticky bit at that edge: RX overrun bit 5, framing bit 6, parity bit 7, RX timeout bit 8, modem status bit 9, TX overflow bit 12.
- R5: A sticky bit stays set until a clear write carries a one in its position, which clears it at that edge.
- R6: When a set source and a clear write hit the same sticky bit at one edge, the bit ends up set.
- R7: A mask-set write ORs its data into the mask.
- R8: A mask-clear write clears the mask bits written as one. If set and clear writes hit the same bit at one edge, the bit ends up clear.
- R9: A direct mask write leaves the mask unchanged.
- R10: irq_o is a register. After each edge it equals the OR of (mask AND sticky) as those registers stand after that same edge.
- R11: The RX and TX trigger levels reset to RX_TRIG_RST and TX_TRIG_RST (32 by default). Each changes to its write data at an edge where its write strobe is high.
- R12: While reset is held, the mask, the sticky register and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | RX_CW | RX FIFO occupancy |
| tx_count | input | TX_CW | TX FIFO occupancy |
| rx_trig_we | input | 1 | RX trigger level write strobe |
| rx_trig_wdata | input | RX_CW | RX trigger level write data |
| tx_trig_we | input | 1 | TX trigger level write strobe |
| tx_trig_wdata | input | TX_CW | TX trigger level write data |
| ev_rx_overrun | input | 1 | RX overrun pulse |
| ev_framing | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | RX timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_overflow | input | 1 | TX overflow pulse |
| mask_set_we | input | 1 | Mask set-only write strobe |
| mask_set_data | input | 13 | Bits to set in the mask |
| mask_clr_we | input | 1 | Mask clear-only write strobe |
| mask_clr_data | input | 13 | Bits to clear in the mask |
| mask_direct_we | input | 1 | Direct mask write strobe (no effect) |
| mask_direct_data | input | 13 | Direct mask write data (no effect) |
| isr_clr_we | input | 1 | Sticky clear write strobe |
| isr_clr_data | input | 13 | Sticky bits to clear |
| status_o | output | 14 | Live status word |
| isr_o | output | 13 | Sticky interrupt register |
| mask_o | output | 13 | Interrupt mask |
| rx_trig_o | output | RX_CW | Current RX trigger level |
| tx_trig_o | output | TX_CW | Current TX trigger level |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench clears the sticky register with an all-ones write at the same edge where new counts and event pulses arrive. A design that let the clear win would then show an empty sticky word instead of the fresh level and event bits. Counts at exactly the trigger level, one below it, at zero and at full depth expose off-by-one comparisons. The TX-trigger flag is checked at bit 13 of the status word and at bit 10 of the sticky word, which catches a design that mirrors it at the same position. Simultaneous set and clear mask writes and a direct mask write show whether the mask ports are kept apart. Watching irq_o fall after a mask clear, while the sticky bit stays set, catches an interrupt line that ignores the mask.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  // Widths of the status word and the sticky / mask registers
  localparam int ST_W = 14;
  localparam int SK_W = 13;

  // Status word positions
  localparam int ST_RX_TRIG  = 0;
  localparam int ST_RX_EMPTY = 1;
  localparam int ST_RX_FULL  = 2;
  localparam int ST_TX_EMPTY = 3;
  localparam int ST_TX_FULL  = 4;
  localparam int ST_TX_TRIG  = 13;

  // Number of low status bits mirrored 1:1 into the sticky register
  localparam int MIRROR_W = 5;

  // Sticky register positions
  localparam int SK_RX_OVR  = 5;
  localparam int SK_FRAME   = 6;
  localparam int SK_PARITY  = 7;
  localparam int SK_TIMEOUT = 8;
  localparam int SK_MODEM   = 9;
  localparam int SK_TX_TRIG = 10;
  localparam int SK_TX_OVF  = 12;
endpackage

// File: rtl/sirq_level_watch.sv
// Holds one programmable trigger level and derives empty / full / reached
// flags for one FIFO occupancy count.
module sirq_level_watch #(
  parameter int DEPTH    = 64,
  parameter int TRIG_RST = 32,
  parameter int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_we,
  input  logic [CW-1:0] trig_wdata,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] trig_q,
  output logic          empty_o,
  output logic          full_o,
  output logic          reach_o
);
  localparam logic [CW-1:0] FULL_VAL = CW'(DEPTH);
  localparam logic [CW-1:0] RST_VAL  = CW'(TRIG_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trig_q <= RST_VAL;
    else if (trig_we) trig_q <= trig_wdata;
  end

  always_comb begin
    empty_o = (count == '0);
    full_o  = (count == FULL_VAL);
    reach_o = (count >= trig_q);
  end
endmodule

// File: rtl/sirq_sticky.sv
// Sticky interrupt register: write-one-to-clear, with sources winning
// over a clear aimed at the same bit.
module sirq_sticky
  import sirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SK_W-1:0] set_vec,
  input  logic            clr_we,
  input  logic [SK_W-1:0] clr_data,
  output logic [SK_W-1:0] sticky_q,
  output logic [SK_W-1:0] sticky_d
);
  logic [SK_W-1:0] clr_eff;

  always_comb begin
    clr_eff  = clr_we ? clr_data : '0;
    sticky_d = (sticky_q & ~clr_eff) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_d;
  end
endmodule

// File: rtl/sirq_mask.sv
// Interrupt mask changed only through set-only and clear-only ports.
// Clear is applied after set, so a clear wins on a shared bit.
module sirq_mask
  import sirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic [SK_W-1:0] set_data,
  input  logic            clr_we,
  input  logic [SK_W-1:0] clr_data,
  output logic [SK_W-1:0] mask_q,
  output logic [SK_W-1:0] mask_d
);
  logic [SK_W-1:0] set_eff;
  logic [SK_W-1:0] clr_eff;

  always_comb begin
    set_eff = set_we ? set_data : '0;
    clr_eff = clr_we ? clr_data : '0;
    mask_d  = (mask_q | set_eff) & ~clr_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/serial_irq_hub.sv
module serial_irq_hub
  import sirq_pkg::*;
#(
  parameter int RX_DEPTH    = 64,
  parameter int TX_DEPTH    = 64,
  parameter int RX_TRIG_RST = 32,
  parameter int TX_TRIG_RST = 32,
  localparam int RX_CW      = $clog2(RX_DEPTH + 1),
  localparam int TX_CW      = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RX_CW-1:0] rx_count,
  input  logic [TX_CW-1:0] tx_count,
  input  logic             rx_trig_we,
  input  logic [RX_CW-1:0] rx_trig_wdata,
  input  logic             tx_trig_we,
  input  logic [TX_CW-1:0] tx_trig_wdata,
  input  logic             ev_rx_overrun,
  input  logic             ev_framing,
  input  logic             ev_parity,
  input  logic             ev_rx_timeout,
  input  logic             ev_modem,
  input  logic             ev_tx_overflow,
  input  logic             mask_set_we,
  input  logic [SK_W-1:0]  mask_set_data,
  input  logic             mask_clr_we,
  input  logic [SK_W-1:0]  mask_clr_data,
  input  logic             mask_direct_we,
  input  logic [SK_W-1:0]  mask_direct_data,
  input  logic             isr_clr_we,
  input  logic [SK_W-1:0]  isr_clr_data,
  output logic [ST_W-1:0]  status_o,
  output logic [SK_W-1:0]  isr_o,
  output logic [SK_W-1:0]  mask_o,
  output logic [RX_CW-1:0] rx_trig_o,
  output logic [TX_CW-1:0] tx_trig_o,
  output logic             irq_o
);
  logic rx_empty, rx_full, rx_reach;
  logic tx_empty, tx_full, tx_reach;
  logic [SK_W-1:0] set_vec;
  logic [SK_W-1:0] sticky_d;
  logic [SK_W-1:0] mask_d;
  logic            direct_write_unused;

  // The mask has no direct write path; the port pair is accepted and dropped.
  assign direct_write_unused = mask_direct_we ^ (^mask_direct_data);

  sirq_level_watch #(
    .DEPTH(RX_DEPTH), .TRIG_RST(RX_TRIG_RST), .CW(RX_CW)
  ) u_rx_watch (
    .clk(clk), .rst_n(rst_n),
    .trig_we(rx_trig_we), .trig_wdata(rx_trig_wdata),
    .count(rx_count), .trig_q(rx_trig_o),
    .empty_o(rx_empty), .full_o(rx_full), .reach_o(rx_reach)
  );

  sirq_level_watch #(
    .DEPTH(TX_DEPTH), .TRIG_RST(TX_TRIG_RST), .CW(TX_CW)
  ) u_tx_watch (
    .clk(clk), .rst_n(rst_n),
    .trig_we(tx_trig_we), .trig_wdata(tx_trig_wdata),
    .count(tx_count), .trig_q(tx_trig_o),
    .empty_o(tx_empty), .full_o(tx_full), .reach_o(tx_reach)
  );

  // Live status word
  always_comb begin
    status_o              = '0;
    status_o[ST_RX_TRIG]  = rx_reach;
    status_o[ST_RX_EMPTY] = rx_empty;
    status_o[ST_RX_FULL]  = rx_full;
    status_o[ST_TX_EMPTY] = tx_empty;
    status_o[ST_TX_FULL]  = tx_full;
    status_o[ST_TX_TRIG]  = tx_reach;
  end

  // Sticky sources: mirrored level flags plus event pulses
  always_comb begin
    set_vec                 = '0;
    set_vec[MIRROR_W-1:0]   = status_o[MIRROR_W-1:0];
    set_vec[SK_TX_TRIG]     = status_o[ST_TX_TRIG];
    set_vec[SK_RX_OVR]      = ev_rx_overrun;
    set_vec[SK_FRAME]       = ev_framing;
    set_vec[SK_PARITY]      = ev_parity;
    set_vec[SK_TIMEOUT]     = ev_rx_timeout;
    set_vec[SK_MODEM]       = ev_modem;
    set_vec[SK_TX_OVF]      = ev_tx_overflow;
  end

  sirq_sticky u_sticky (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec),
    .clr_we(isr_clr_we), .clr_data(isr_clr_data),
    .sticky_q(isr_o), .sticky_d(sticky_d)
  );

  sirq_mask u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_we(mask_set_we), .set_data(mask_set_data),
    .clr_we(mask_clr_we), .clr_data(mask_clr_data),
    .mask_q(mask_o), .mask_d(mask_d)
  );

  // Registered interrupt line, aligned with the registers it summarises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(mask_d & sticky_d);
  end
endmodule

// File: rtl/serial_irq_hub_chk.sv
module serial_irq_hub_chk
  import sirq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [ST_W-1:0] status_o,
  input logic [SK_W-1:0] isr_o,
  input logic [SK_W-1:0] mask_o,
  input logic            irq_o,
  input logic            ev_rx_overrun,
  input logic            ev_modem,
  input logic            isr_clr_we,
  input logic [SK_W-1:0] isr_clr_data,
  input logic            mask_set_we,
  input logic [SK_W-1:0] mask_set_data,
  input logic            mask_clr_we,
  input logic [SK_W-1:0] mask_clr_data
);
  a_r3_level_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((isr_o[4:0] & $past(status_o[4:0])) == $past(status_o[4:0])));

  a_r3_tx_trig_moved: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && status_o[ST_TX_TRIG]) |=> isr_o[SK_TX_TRIG]);

  a_r3_gap_bit: assert property (@(posedge clk) disable iff (!rst_n)
    isr_o[11] == 1'b0);

  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && ev_rx_overrun) |=> isr_o[SK_RX_OVR]);

  a_r5_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !isr_clr_we) |=> ((isr_o & $past(isr_o)) == $past(isr_o)));

  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && ev_modem && isr_clr_we && isr_clr_data[SK_MODEM]) |=> isr_o[SK_MODEM]);

  a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && mask_set_we && !mask_clr_we) |=>
      ((mask_o & $past(mask_set_data)) == $past(mask_set_data)));

  a_r8_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && mask_clr_we) |=> ((mask_o & $past(mask_clr_data)) == '0));

  a_r9_mask_only_via_ports: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !mask_set_we && !mask_clr_we) |=> $stable(mask_o));

  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(mask_o & isr_o)));
endmodule

bind serial_irq_hub serial_irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .status_o(status_o), .isr_o(isr_o), .mask_o(mask_o), .irq_o(irq_o),
  .ev_rx_overrun(ev_rx_overrun), .ev_modem(ev_modem),
  .isr_clr_we(isr_clr_we), .isr_clr_data(isr_clr_data),
  .mask_set_we(mask_set_we), .mask_set_data(mask_set_data),
  .mask_clr_we(mask_clr_we), .mask_clr_data(mask_clr_data)
);

// File: tb/serial_irq_hub_bench.sv
module serial_irq_hub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  rx_count = '0, tx_count = '0;
  logic        rx_trig_we = 1'b0, tx_trig_we = 1'b0;
  logic [6:0]  rx_trig_wdata = '0, tx_trig_wdata = '0;
  logic        ev_rx_overrun = 0, ev_framing = 0, ev_parity = 0;
  logic        ev_rx_timeout = 0, ev_modem = 0, ev_tx_overflow = 0;
  logic        mask_set_we = 0, mask_clr_we = 0, mask_direct_we = 0, isr_clr_we = 0;
  logic [12:0] mask_set_data = '0, mask_clr_data = '0, mask_direct_data = '0, isr_clr_data = '0;
  logic [13:0] status_o;
  logic [12:0] isr_o, mask_o;
  logic [6:0]  rx_trig_o, tx_trig_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  serial_irq_hub u_serial_irq_hub (
    .clk(clk), .rst_n(rst_n),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_trig_we(rx_trig_we), .rx_trig_wdata(rx_trig_wdata),
    .tx_trig_we(tx_trig_we), .tx_trig_wdata(tx_trig_wdata),
    .ev_rx_overrun(ev_rx_overrun), .ev_framing(ev_framing),
    .ev_parity(ev_parity), .ev_rx_timeout(ev_rx_timeout),
    .ev_modem(ev_modem), .ev_tx_overflow(ev_tx_overflow),
    .mask_set_we(mask_set_we), .mask_set_data(mask_set_data),
    .mask_clr_we(mask_clr_we), .mask_clr_data(mask_clr_data),
    .mask_direct_we(mask_direct_we), .mask_direct_data(mask_direct_data),
    .isr_clr_we(isr_clr_we), .isr_clr_data(isr_clr_data),
    .status_o(status_o), .isr_o(isr_o), .mask_o(mask_o),
    .rx_trig_o(rx_trig_o), .tx_trig_o(tx_trig_o), .irq_o(irq_o)
  );

  // {rx_count, tx_count, events[5:0], expected status}
  // events: 0 overrun, 1 framing, 2 parity, 3 timeout, 4 modem, 5 tx overflow
  localparam logic [33:0] VECS [0:7] = '{
    {7'd0,  7'd0,  6'b000000, 14'h000A},
    {7'd64, 7'd64, 6'b000000, 14'h2015},
    {7'd31, 7'd32, 6'b000000, 14'h2000},
    {7'd32, 7'd31, 6'b000001, 14'h0001},
    {7'd10, 7'd0,  6'b000110, 14'h0008},
    {7'd0,  7'd5,  6'b111000, 14'h0002},
    {7'd63, 7'd63, 6'b111111, 14'h2001},
    {7'd1,  7'd64, 6'b000000, 14'h2010}
  };

  function automatic logic [12:0] exp_sticky(logic [13:0] st, logic [5:0] ev);
    logic [12:0] s;
    s       = '0;
    s[4:0]  = st[4:0];
    s[10]   = st[13];
    s[5]    = ev[0];
    s[6]    = ev[1];
    s[7]    = ev[2];
    s[8]    = ev[3];
    s[9]    = ev[4];
    s[12]   = ev[5];
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_events(logic [5:0] ev);
    ev_rx_overrun  = ev[0];
    ev_framing     = ev[1];
    ev_parity      = ev[2];
    ev_rx_timeout  = ev[3];
    ev_modem       = ev[4];
    ev_tx_overflow = ev[5];
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R12 watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // Reset state (R11, R12)
    repeat (2) @(negedge clk);
    chk("R12 mask in reset", 32'(mask_o), 32'h0);
    chk("R12 sticky in reset", 32'(isr_o), 32'h0);
    chk("R12 irq in reset", 32'(irq_o), 32'h0);
    chk("R11 rx trigger reset", 32'(rx_trig_o), 32'd32);
    chk("R11 tx trigger reset", 32'(tx_trig_o), 32'd32);
    rst_n = 1'b1;
    tick();

    // Vector table: R1/R2 status, R3/R4 sticky, R6 set over a full clear
    for (int i = 0; i < 8; i++) begin
      rx_count     = VECS[i][33:27];
      tx_count     = VECS[i][26:20];
      set_events(VECS[i][19:14]);
      isr_clr_we   = 1'b1;
      isr_clr_data = '1;
      #1;
      chk("R1 R2 status word", 32'(status_o), 32'(VECS[i][13:0]));
      @(negedge clk);
      set_events('0);
      isr_clr_we = 1'b0;
      chk("R3 R4 R6 sticky after set+clear", 32'(isr_o),
          32'(exp_sticky(VECS[i][13:0], VECS[i][19:14])));
      chk("R10 irq with empty mask", 32'(irq_o), 32'h0);
    end

    // Neutral counts: no level flags
    rx_count = 7'd10; tx_count = 7'd10;
    isr_clr_we = 1'b1; isr_clr_data = '1;
    tick();
    isr_clr_we = 1'b0;
    tick();
    chk("R5 sticky stays clear with no source", 32'(isr_o), 32'h0);

    // Mask ports (R7, R8, R9)
    mask_set_we = 1'b1; mask_set_data = 13'h0021;
    tick();
    mask_set_data = 13'h0100;
    tick();
    mask_set_we = 1'b0;
    chk("R7 mask set ORs", 32'(mask_o), 32'h0121);
    mask_clr_we = 1'b1; mask_clr_data = 13'h0001;
    tick();
    mask_clr_we = 1'b0;
    chk("R8 mask clear", 32'(mask_o), 32'h0120);
    mask_direct_we = 1'b1; mask_direct_data = 13'h1FFF;
    tick();
    mask_direct_we = 1'b0;
    chk("R9 direct mask write ignored", 32'(mask_o), 32'h0120);
    mask_set_we = 1'b1; mask_set_data = 13'h0002;
    mask_clr_we = 1'b1; mask_clr_data = 13'h0002;
    tick();
    mask_set_we = 1'b0; mask_clr_we = 1'b0;
    chk("R8 clear wins over set on mask", 32'(mask_o), 32'h0120);

    // Interrupt line (R4, R5, R10)
    ev_rx_overrun = 1'b1;
    tick();
    ev_rx_overrun = 1'b0;
    chk("R4 overrun sticky", 32'(isr_o), 32'h0020);
    chk("R10 irq rises with masked bit", 32'(irq_o), 32'h1);
    tick();
    chk("R5 sticky persists", 32'(isr_o), 32'h0020);
    chk("R10 irq held", 32'(irq_o), 32'h1);
    isr_clr_we = 1'b1; isr_clr_data = 13'h0020;
    tick();
    isr_clr_we = 1'b0;
    chk("R5 write-one clears", 32'(isr_o), 32'h0);
    chk("R10 irq falls after clear", 32'(irq_o), 32'h0);

    ev_rx_timeout = 1'b1;
    tick();
    ev_rx_timeout = 1'b0;
    chk("R10 irq from timeout", 32'(irq_o), 32'h1);
    mask_clr_we = 1'b1; mask_clr_data = 13'h0100;
    tick();
    mask_clr_we = 1'b0;
    chk("R10 irq gated by mask", 32'(irq_o), 32'h0);
    chk("R5 sticky kept when masked", 32'(isr_o), 32'h0100);

    // Set wins over clear on the sticky register (R6)
    ev_modem = 1'b1; isr_clr_we = 1'b1; isr_clr_data = 13'h1FFF;
    tick();
    ev_modem = 1'b0; isr_clr_we = 1'b0;
    chk("R6 modem set beats clear", 32'(isr_o), 32'h0200);

    // Trigger programming (R11, R1, R2, R3)
    rx_trig_we = 1'b1; rx_trig_wdata = 7'd5;
    tx_trig_we = 1'b1; tx_trig_wdata = 7'd3;
    tick();
    rx_trig_we = 1'b0; tx_trig_we = 1'b0;
    chk("R11 rx trigger written", 32'(rx_trig_o), 32'd5);
    chk("R11 tx trigger written", 32'(tx_trig_o), 32'd3);
    rx_count = 7'd5; tx_count = 7'd2;
    #1;
    chk("R1 rx at new trigger", 32'(status_o), 32'h0001);
    rx_count = 7'd4; tx_count = 7'd3;
    isr_clr_we = 1'b1; isr_clr_data = '1;
    #1;
    chk("R2 tx at new trigger", 32'(status_o), 32'h2000);
    @(negedge clk);
    isr_clr_we = 1'b0;
    chk("R3 tx trigger lands at sticky bit 10", 32'(isr_o), 32'h0400);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule